// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer

The block holds two 8-bit up-counters, channel A and channel B. Each counter is compared with its own modulo register. When a counting tick finds the counter equal to its modulo value, the counter returns to zero and the channel raises a one-cycle interrupt pulse. Counting ticks come from three prescaler tap inputs, which are one-cycle enable pulses in the block's clock domain. Channel A may instead count rising edges of an asynchronous event input. When channel B's source field selects cascade, the two counters form a single 16-bit counter. That 16-bit counter runs under channel A's controls and reports on channel A's interrupt.

An 8-bit mode register holds all the controls. Each channel is run by a small control state machine with three states: STOPPED, RUNNING and PAUSED. The machine moves to STOPPED whenever the channel's start bit is 0, and the counter is cleared while the machine is in STOPPED. With the start bit at 1, the machine moves to RUNNING when the continue bit is 1, and to PAUSED when it is 0. Every transition between these states is reached directly from the current mode bits. Channel B has no continue bit, so for channel B that input is tied to 1.

Channel B drives a square-wave output that toggles on each channel B match, or on each pair match in cascade mode. When enabled, a capture input latches channel A's count into a readable register.

Top module: `tmr_dual8`

## Requirements
- R1: After reset, both counts, the mode readback, the capture register, both interrupts and the square-wave output are 0.
- R2: The mode register fields are: bit 7 capture enable, bit 6 channel B start, bits 5:4 channel B source, bit 3 channel A start, bit 2 channel A continue, bits 1:0 channel A source. `mode_rd` returns the last value written.
- R3: The channel A source codes are: 00 the synchronized event input, 01 `tap[0]`, 10 `tap[1]`, 11 `tap[2]`. A tap that is not selected has no effect on the count.
- R4: The channel B source codes are: 01 `tap[0]`, 10 `tap[1]`, 11 `tap[2]`, and 00 selects 16-bit cascade. A tap that is not selected has no effect on the count.
- R5: A counting tick that finds the count equal to the modulo value sets the count to 0 and pulses that channel's interrupt for exactly one cycle. Any other tick increments the count by 1.
- R6: With channel A's start bit at 1 and continue bit at 0, ticks leave channel A's count unchanged. Setting continue back to 1 resumes counting from the held value.
- R7: A start bit at 0 clears its channel's count to 0 by the second clock edge after the mode write. Ticks at the third edge and later are counted, starting from 0.
- R8: In cascade mode, the counter {B,A} increments as one 16-bit value and is compared with {modulo B, modulo A}. It is controlled only by channel A's start and continue bits, reports on `irq0`, and never pulses `irq1`.
- R9: The square-wave output toggles on each channel B match, or on each pair match in cascade mode. It is held at 0 while the owning channel (B, or A in cascade mode) is stopped.
- R10: The event input passes through two synchronizing flip-flops. Each rising edge counts once, and the count changes at the third clock edge after the input rises.
- R11: With capture enabled, a rising edge of the capture input, synchronized the same way, copies channel A's count into `cap_val` and pulses `irq0` at the third edge after the input rises. With capture disabled, the capture input has no effect.
- R12: Writing a modulo register sets that channel's modulo value. The count ports always show the current counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| mode_rd | output | 8 | Mode register readback |
| mod0_we | input | 1 | Channel A modulo write strobe |
| mod1_we | input | 1 | Channel B modulo write strobe |
| mod_wdata | input | W | Modulo write value |
| count0 | output | W | Channel A count |
| count1 | output | W | Channel B count |
| tap | input | NTAP | Prescaler tick enables |
| evt_in | input | 1 | Asynchronous event input |
| cap_in | input | 1 | Asynchronous capture input |
| cap_val | output | W | Captured channel A count |
| irq0 | output | 1 | Channel A (and pair) interrupt pulse |
| irq1 | output | 1 | Channel B interrupt pulse |
| sq_out | output | 1 | Square-wave output |

## Verification
A tap that is high before clock edge e is counted at edge e, so the count and any interrupt pulse are sampled on the falling edge that follows. A mode write at edge k sets the control state at edge k+1, and a stopped counter is cleared at edge k+2. The bench therefore idles two full cycles after every mode write before it issues ticks or samples. Event and capture results are due at the third edge after the input rises. The bench checks that the value is still unchanged after the second edge and has changed after the third.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_RUNNING = 2'd1,
        ST_PAUSED  = 2'd2
    } run_state_e;

    localparam int SELW     = 2;
    localparam int MB_CAPEN = 7;
    localparam int MB_BSTRT = 6;
    localparam int MB_BSRC  = 4;
    localparam int MB_ASTRT = 3;
    localparam int MB_ACONT = 2;
    localparam int MB_ASRC  = 0;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], async_i};
    end

    assign rise_o = sh[STAGES-1] & ~sh[STAGES];

    // R10: one pulse per rising edge
    p_rise_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_ctl_fsm.sv
module tmr_ctl_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cont_i,
    output logic run_o,
    output logic clear_o
);
    run_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STOPPED: begin
                if (start_i && cont_i) state_nx = ST_RUNNING;
                else if (start_i)      state_nx = ST_PAUSED;
            end
            ST_RUNNING: begin
                if (!start_i)     state_nx = ST_STOPPED;
                else if (!cont_i) state_nx = ST_PAUSED;
            end
            ST_PAUSED: begin
                if (!start_i)    state_nx = ST_STOPPED;
                else if (cont_i) state_nx = ST_RUNNING;
            end
            default: state_nx = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOPPED;
        else        state <= state_nx;
    end

    always_comb begin
        run_o   = 1'b0;
        clear_o = 1'b0;
        unique case (state)
            ST_STOPPED: clear_o = 1'b1;
            ST_RUNNING: run_o   = 1'b1;
            ST_PAUSED:  ;
            default:    clear_o = 1'b1;
        endcase
    end

    // R7: a low start bit forces the clearing state on the next cycle
    p_stop_on_low_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> clear_o);
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
    import tmr_pkg::*;
#(
    parameter int NTAP = 3
) (
    input  logic [SELW-1:0] sel_i,
    input  logic [NTAP-1:0] taps_i,
    input  logic            alt_i,
    output logic            tick_o
);
    always_comb begin
        tick_o = alt_i;
        for (int i = 0; i < NTAP; i++) begin
            if (sel_i == SELW'(i + 1)) tick_o = taps_i[i];
        end
    end
endmodule

// File: rtl/tmr_dual8.sv
module tmr_dual8
    import tmr_pkg::*;
#(
    parameter int W           = 8,
    parameter int NTAP        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_we,
    input  logic [7:0]      mode_wdata,
    output logic [7:0]      mode_rd,
    input  logic            mod0_we,
    input  logic            mod1_we,
    input  logic [W-1:0]    mod_wdata,
    output logic [W-1:0]    count0,
    output logic [W-1:0]    count1,
    input  logic [NTAP-1:0] tap,
    input  logic            evt_in,
    input  logic            cap_in,
    output logic [W-1:0]    cap_val,
    output logic            irq0,
    output logic            irq1,
    output logic            sq_out
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [7:0]   mode_r;
    logic [W-1:0] mod0_r, mod1_r, cnt0_r, cnt1_r, cap_r;
    logic         irq0_r, irq1_r, sq_r;

    logic run0, clr0, run1, clr1;
    logic evt_rise, cap_rise, tick0, tick1;
    logic casc, cap_en, adv0, adv1, hit0, hit1, hit_pair, match0, match1;
    logic sq_clr, sq_tgl;

    assign casc   = (mode_r[MB_BSRC +: SELW] == '0);
    assign cap_en = mode_r[MB_CAPEN];

    tmr_ctl_fsm u_fsm_a (
        .clk(clk), .rst_n(rst_n),
        .start_i(mode_r[MB_ASTRT]), .cont_i(mode_r[MB_ACONT]),
        .run_o(run0), .clear_o(clr0)
    );

    tmr_ctl_fsm u_fsm_b (
        .clk(clk), .rst_n(rst_n),
        .start_i(mode_r[MB_BSTRT]), .cont_i(1'b1),
        .run_o(run1), .clear_o(clr1)
    );

    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_evt (
        .clk(clk), .rst_n(rst_n), .async_i(evt_in), .rise_o(evt_rise)
    );

    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_cap (
        .clk(clk), .rst_n(rst_n), .async_i(cap_in), .rise_o(cap_rise)
    );

    tmr_tick_sel #(.NTAP(NTAP)) u_sel_a (
        .sel_i(mode_r[MB_ASRC +: SELW]), .taps_i(tap), .alt_i(evt_rise), .tick_o(tick0)
    );

    tmr_tick_sel #(.NTAP(NTAP)) u_sel_b (
        .sel_i(mode_r[MB_BSRC +: SELW]), .taps_i(tap), .alt_i(1'b0), .tick_o(tick1)
    );

    assign adv0     = run0 & tick0;
    assign adv1     = ~casc & run1 & tick1;
    assign hit0     = (cnt0_r == mod0_r);
    assign hit1     = (cnt1_r == mod1_r);
    assign hit_pair = ({cnt1_r, cnt0_r} == {mod1_r, mod0_r});
    assign match0   = adv0 & (casc ? hit_pair : hit0);
    assign match1   = adv1 & hit1;
    assign sq_clr   = casc ? clr0 : clr1;
    assign sq_tgl   = casc ? match0 : match1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_r <= '0;
            mod0_r <= '0;
            mod1_r <= '0;
        end else begin
            if (mode_we) mode_r <= mode_wdata;
            if (mod0_we) mod0_r <= mod_wdata;
            if (mod1_we) mod1_r <= mod_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt0_r <= '0;
        end else if (clr0) begin
            cnt0_r <= '0;
        end else if (adv0) begin
            cnt0_r <= match0 ? '0 : cnt0_r + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt1_r <= '0;
        end else if (casc) begin
            if (clr0)
                cnt1_r <= '0;
            else if (adv0)
                cnt1_r <= match0 ? '0 : ((cnt0_r == CNT_MAX) ? cnt1_r + 1'b1 : cnt1_r);
        end else if (clr1) begin
            cnt1_r <= '0;
        end else if (adv1) begin
            cnt1_r <= match1 ? '0 : cnt1_r + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_r  <= '0;
            irq0_r <= 1'b0;
            irq1_r <= 1'b0;
            sq_r   <= 1'b0;
        end else begin
            if (cap_en && cap_rise) cap_r <= cnt0_r;
            irq0_r <= match0 | (cap_en & cap_rise);
            irq1_r <= match1;
            if (sq_clr)      sq_r <= 1'b0;
            else if (sq_tgl) sq_r <= ~sq_r;
        end
    end

    assign mode_rd = mode_r;
    assign count0  = cnt0_r;
    assign count1  = cnt1_r;
    assign cap_val = cap_r;
    assign irq0    = irq0_r;
    assign irq1    = irq1_r;
    assign sq_out  = sq_r;

    // R5: an 8-bit match returns channel A to zero and pulses its interrupt
    p_wrap_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!casc && run0 && tick0 && cnt0_r == mod0_r) |=> (cnt0_r == '0 && irq0));

    // R6: a paused channel A keeps its count
    p_hold_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run0 && !clr0) |=> (cnt0_r == $past(cnt0_r)));

    // R8: cascade mode never reports on channel B's interrupt
    p_casc_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        casc |=> !irq1);

    // R9: the square wave is forced low while its owner is stopped
    p_sq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!casc && clr1) |=> !sq_out);

    // R11: an enabled capture latches channel A's count and pulses irq0
    p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && cap_rise) |=> (cap_val == $past(cnt0_r) && irq0));
endmodule

// File: tb/test_tmr_dual8.sv
`timescale 1ns/1ps
module test_tmr_dual8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic [7:0] mode_rd;
    logic       mod0_we = 1'b0, mod1_we = 1'b0;
    logic [7:0] mod_wdata = '0;
    logic [7:0] count0, count1, cap_val;
    logic [2:0] tap = '0;
    logic       evt_in = 1'b0, cap_in = 1'b0;
    logic       irq0, irq1, sq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_dual8 i_tmr_dual8 (
        .clk(clk), .rst_n(rst_n),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_rd(mode_rd),
        .mod0_we(mod0_we), .mod1_we(mod1_we), .mod_wdata(mod_wdata),
        .count0(count0), .count1(count1), .tap(tap),
        .evt_in(evt_in), .cap_in(cap_in), .cap_val(cap_val),
        .irq0(irq0), .irq1(irq1), .sq_out(sq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_mode(input logic [7:0] v);
        @(negedge clk); mode_we = 1'b1; mode_wdata = v;
        @(negedge clk); mode_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_mod(input int ch, input logic [7:0] v);
        @(negedge clk); mod_wdata = v;
        if (ch == 0) mod0_we = 1'b1; else mod1_we = 1'b1;
        @(negedge clk); mod0_we = 1'b0; mod1_we = 1'b0;
    endtask

    task automatic ticks(input int idx, input int n);
        tap[idx] = 1'b1;
        repeat (n) @(negedge clk);
        tap = '0;
    endtask

    task automatic t_reset;
        check("R1 count0", count0, 0);
        check("R1 count1", count1, 0);
        check("R1 mode_rd", mode_rd, 0);
        check("R1 cap_val", cap_val, 0);
        check("R1 irqs/sq", {irq0, irq1, sq_out}, 0);
    endtask

    task automatic t_basic;
        wr_mod(0, 8'd4);
        wr_mode(8'h0D);
        check("R2 mode readback", mode_rd, 8'h0D);
        ticks(0, 3);
        check("R12 count after 3 ticks", count0, 3);
        ticks(1, 3);
        check("R3 unselected tap ignored", count0, 3);
        ticks(0, 1);
        check("R5 reaches modulo", {irq0, count0}, {1'b0, 8'd4});
        ticks(0, 1);
        check("R5 wrap to zero with irq0", {irq0, count0}, {1'b1, 8'd0});
        @(negedge clk);
        check("R5 irq0 one cycle", irq0, 0);
    endtask

    task automatic t_pause;
        ticks(0, 2);
        check("R6 before pause", count0, 2);
        wr_mode(8'h09);
        ticks(0, 3);
        check("R6 paused holds", count0, 2);
        wr_mode(8'h0D);
        ticks(0, 1);
        check("R6 resume from held", count0, 3);
    endtask

    task automatic t_stop;
        wr_mode(8'h05);
        check("R7 stop clears", count0, 0);
        wr_mode(8'h0D);
        ticks(0, 2);
        check("R7 restart from zero", count0, 2);
        wr_mode(8'h0F);
        ticks(2, 1);
        check("R3 code 11 uses tap2", count0, 3);
        ticks(0, 2);
        check("R3 tap0 ignored under code 11", count0, 3);
    endtask

    task automatic t_chan_b;
        wr_mode(8'h00);
        wr_mod(1, 8'd2);
        wr_mode(8'h60);
        ticks(1, 2);
        check("R4 B counts tap1", {sq_out, count1}, {1'b0, 8'd2});
        ticks(1, 1);
        check("R9 first match toggles", {irq1, sq_out, count1}, {1'b1, 1'b1, 8'd0});
        ticks(0, 2);
        check("R4 B ignores tap0", count1, 0);
        ticks(1, 3);
        check("R9 second match toggles back", sq_out, 0);
        ticks(1, 3);
        check("R9 third match", sq_out, 1);
        wr_mode(8'h00);
        check("R9 stop clears square wave", {sq_out, count1}, {1'b0, 8'd0});
    endtask

    task automatic t_cascade;
        bit seen1 = 1'b0;
        wr_mod(0, 8'd1);
        wr_mod(1, 8'd1);
        wr_mode(8'h0D);
        tap[0] = 1'b1;
        repeat (255) begin
            @(negedge clk);
            if (irq1 || irq0) seen1 = 1'b1;
        end
        tap = '0;
        check("R8 no irq before pair match", seen1, 0);
        check("R8 low byte full", {count1, count0}, 16'h00FF);
        ticks(0, 1);
        check("R8 carry into high byte", {count1, count0}, 16'h0100);
        ticks(0, 1);
        check("R8 at pair modulo", {irq0, count1, count0}, {1'b0, 16'h0101});
        ticks(0, 1);
        check("R8 pair wraps, irq0 only", {irq0, irq1, count1, count0}, {2'b10, 16'h0000});
        check("R9 pair match toggles", sq_out, 1);
        wr_mode(8'h09);
        ticks(0, 2);
        check("R8 paused by channel A continue", {count1, count0}, 16'h0000);
        wr_mode(8'h00);
    endtask

    task automatic t_event;
        wr_mod(0, 8'hFF);
        wr_mode(8'h0C);
        evt_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 not yet after two edges", count0, 0);
        @(negedge clk);
        check("R10 counted at third edge", count0, 1);
        for (int k = 0; k < 2; k++) begin
            repeat (3) @(negedge clk);
            evt_in = 1'b0;
            repeat (3) @(negedge clk);
            evt_in = 1'b1;
        end
        repeat (4) @(negedge clk);
        evt_in = 1'b0;
        check("R10 three edges counted once each", count0, 3);
    endtask

    task automatic t_capture;
        wr_mode(8'h00);
        wr_mode(8'h8D);
        ticks(0, 5);
        cap_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 not latched after two edges", {irq0, cap_val}, {1'b0, 8'd0});
        @(negedge clk);
        check("R11 latched with irq0", {irq0, cap_val}, {1'b1, 8'd5});
        @(negedge clk);
        check("R11 irq0 one cycle", irq0, 0);
        cap_in = 1'b0;
        wr_mode(8'h0D);
        ticks(0, 2);
        cap_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 disabled capture ignored", {irq0, cap_val}, {1'b0, 8'd5});
        cap_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_pause();
        t_stop();
        t_chan_b();
        t_cascade();
        t_event();
        t_capture();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule